// File: doc/BRIEF.md
# Double-Rate Read Beat Serializer

This block sits on the read side of a double-data-rate memory output path. The core delivers one prefetched word of twice the pin width per core clock. The block splits each word into two pin-width beats, one in each half of the core clock. It drives a read strobe that toggles at every beat boundary. A programmable read latency, which can be a whole or a half number of core cycles, places the first beat. The burst length sets how many beats one read produces.

The block runs entirely on a clock at twice the core rate, so that every half of a core cycle is one fast cycle. A phase bit is cleared by reset and toggles on every fast edge. The fast edge on which this bit is zero (the first fast edge after reset release, and every second edge after it) is the core edge, and commands and words are sampled only there. An enable output marks the window in which the strobe and data pins are driven. When the enable is low, both pins are treated as released.

Top module: `ddr_rd_serializer`

## Requirements
- R1: During reset and on the first fast edge after it, `oe_o`, `dqs_o` and `dq_o` are all zero.
- R2: `rd_start_i` and `word_i` are sampled only on even fast edges, counting the first fast edge after reset release as edge 0. A start pulse seen on an odd edge has no effect on the outputs.
- R3: `bl_code_i` is captured with the start and sets the number of beats: 0 gives 2 beats, 1 gives 4 beats, and 2 or 3 give 8 beats.
- R4: `lat_code_i` is captured with the start and sets the read latency: 0 is 4 fast cycles, 1 is 5, and 2 or 3 are 6. If the start is sampled on fast edge E, the first beat is on `dq_o` just after edge E plus the latency.
- R5: Each word goes out as two beats: bits [DQ_W-1:0] first, then bits [2*DQ_W-1:DQ_W] one fast cycle later.
- R6: While a beat is driven, `dqs_o` is 1 for a lower-half beat and 0 for an upper-half beat. The strobe therefore changes level at every beat boundary.
- R7: `oe_o` rises two fast cycles before the first beat of a burst, and `dqs_o` stays 0 during both of those cycles.
- R8: After the last beat, `oe_o` stays high with `dqs_o` at 0 for one fast cycle, and then falls.
- R9: Whenever `oe_o` is 0, `dqs_o` and `dq_o` are 0.
- R10: A start sampled on the core edge that follows the burst's last word continues the beat stream with no gap. A start one core cycle later keeps `oe_o` high across the gap.
- R11: For a burst started on edge E, word j is sampled on edge E+2j, and j runs from 0 to (beats/2 - 1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk2x_i | input | 1 | Clock at twice the core rate |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| rd_start_i | input | 1 | Read start, sampled on even fast edges |
| bl_code_i | input | 2 | Burst length code |
| lat_code_i | input | 2 | Read latency code |
| word_i | input | 2*DQ_W | Prefetched word from the core |
| dq_o | output | DQ_W | Serialized data beat |
| dqs_o | output | 1 | Read strobe level |
| oe_o | output | 1 | Drive enable for strobe and data |

## Verification
On every cycle, the assertions check the shape of the strobe. The pins are quiet while the enable is low. A high strobe level is always followed by a low beat. Each enable window opens with two low cycles and closes after a low cycle. The burst counter stays in range. Only the bench scenarios can show that beats land at the exact latency for each code, that the beat count follows the burst code, and that halves come out in the right order with the right data. They also show that odd-phase starts are ignored and that back-to-back bursts join with no gap.

// File: rtl/ddr_rd_ser_pkg.sv
package ddr_rd_ser_pkg;

    localparam int unsigned LAT_W  = 3;
    localparam int unsigned LEFT_W = 3;

    // words per burst for a burst-length code
    function automatic logic [LEFT_W-1:0] bl_words(input logic [1:0] code);
        unique case (code)
            2'd0:    bl_words = 3'd1;
            2'd1:    bl_words = 3'd2;
            default: bl_words = 3'd4;
        endcase
    endfunction

    // read latency in fast (half-core) cycles for a latency code
    function automatic logic [LAT_W-1:0] lat_halves(input logic [1:0] code);
        unique case (code)
            2'd0:    lat_halves = 3'd4;
            2'd1:    lat_halves = 3'd5;
            default: lat_halves = 3'd6;
        endcase
    endfunction

endpackage

// File: rtl/rd_word_feed.sv
module rd_word_feed
    import ddr_rd_ser_pkg::*;
#(
    parameter int unsigned DQ_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_start_i,
    input  logic [1:0]           bl_code_i,
    input  logic [1:0]           lat_code_i,
    input  logic [2*DQ_W-1:0]    word_i,
    output logic                 slot_v_o,
    output logic                 slot_hi_o,
    output logic [DQ_W-1:0]      slot_dq_o,
    output logic [LAT_W-1:0]     lat_h_o,
    output logic [LEFT_W-1:0]    words_left_o
);

    typedef struct packed {
        logic                ph;
        logic [LEFT_W-1:0]   left;
        logic [LAT_W-1:0]    lat;
        logic                up_vld;
        logic [DQ_W-1:0]     upper;
        logic                s_v;
        logic                s_hi;
        logic [DQ_W-1:0]     s_dq;
    } feed_t;

    feed_t st_d, st_q;
    logic  take;

    always_comb begin
        st_d = st_q;
        st_d.ph = ~st_q.ph;
        take = 1'b0;
        if (!st_q.ph) begin
            // core edge: accept a start and/or the next burst word
            take = rd_start_i || (st_q.left != '0);
            if (rd_start_i) begin
                st_d.left = bl_words(bl_code_i) - 3'd1;
                st_d.lat  = lat_halves(lat_code_i);
            end else if (st_q.left != '0) begin
                st_d.left = st_q.left - 3'd1;
            end
            st_d.s_v    = take;
            st_d.s_hi   = 1'b0;
            st_d.s_dq   = take ? word_i[DQ_W-1:0] : '0;
            st_d.upper  = take ? word_i[2*DQ_W-1:DQ_W] : '0;
            st_d.up_vld = take;
        end else begin
            // second half: emit the stashed upper half
            st_d.s_v    = st_q.up_vld;
            st_d.s_hi   = 1'b1;
            st_d.s_dq   = st_q.up_vld ? st_q.upper : '0;
            st_d.up_vld = 1'b0;
            st_d.upper  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.lat <= 3'd4;
        end else begin
            st_q <= st_d;
        end
    end

    assign slot_v_o     = st_q.s_v;
    assign slot_hi_o    = st_q.s_hi;
    assign slot_dq_o    = st_q.s_dq;
    assign lat_h_o      = st_q.lat;
    assign words_left_o = st_q.left;

endmodule

// File: rtl/rd_slot_delay.sv
module rd_slot_delay #(
    parameter int unsigned DQ_W  = 8,
    parameter int unsigned TAP_N = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_v_i,
    input  logic                          in_hi_i,
    input  logic [DQ_W-1:0]               in_dq_i,
    output logic [TAP_N:1]                tap_v_o,
    output logic [TAP_N:1]                tap_hi_o,
    output logic [TAP_N:1][DQ_W-1:0]      tap_dq_o
);

    typedef struct packed {
        logic            v;
        logic            hi;
        logic [DQ_W-1:0] dq;
    } slot_t;

    slot_t chain_d [TAP_N:1];
    slot_t chain_q [TAP_N:1];

    always_comb begin
        chain_d[1] = '{v: in_v_i, hi: in_hi_i, dq: in_dq_i};
        for (int k = 2; k <= TAP_N; k++) begin
            chain_d[k] = chain_q[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 1; k <= TAP_N; k++) begin
                chain_q[k] <= '0;
            end
        end else begin
            for (int k = 1; k <= TAP_N; k++) begin
                chain_q[k] <= chain_d[k];
            end
        end
    end

    for (genvar g = 1; g <= TAP_N; g++) begin : g_tap
        assign tap_v_o[g]  = chain_q[g].v;
        assign tap_hi_o[g] = chain_q[g].hi;
        assign tap_dq_o[g] = chain_q[g].dq;
    end

endmodule

// File: rtl/rd_beat_drive.sv
module rd_beat_drive
    import ddr_rd_ser_pkg::*;
#(
    parameter int unsigned DQ_W  = 8,
    parameter int unsigned TAP_N = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [LAT_W-1:0]              lat_h_i,
    input  logic [TAP_N:1]                tap_v_i,
    input  logic [TAP_N:1]                tap_hi_i,
    input  logic [TAP_N:1][DQ_W-1:0]      tap_dq_i,
    output logic                          oe_o,
    output logic                          dqs_o,
    output logic [DQ_W-1:0]               dq_o
);

    localparam int unsigned IDX_W = $clog2(TAP_N + 1);

    typedef struct packed {
        logic            oe;
        logic            dqs;
        logic [DQ_W-1:0] dq;
    } pin_t;

    pin_t pin_d, pin_q;
    logic win;
    logic beat_v;
    logic beat_hi;
    logic [DQ_W-1:0] beat_dq;

    always_comb begin
        // drive window spans taps L-3 (preamble start) to L (postamble)
        win = 1'b0;
        for (int k = 0; k < 4; k++) begin
            int idx;
            idx = int'(lat_h_i) - 3 + k;
            if (idx >= 1 && idx <= int'(TAP_N)) begin
                win = win | tap_v_i[IDX_W'(idx)];
            end
        end
        beat_v  = 1'b0;
        beat_hi = 1'b0;
        beat_dq = '0;
        begin
            int bidx;
            bidx = int'(lat_h_i) - 1;
            if (bidx >= 1 && bidx <= int'(TAP_N)) begin
                beat_v  = tap_v_i[IDX_W'(bidx)];
                beat_hi = tap_hi_i[IDX_W'(bidx)];
                beat_dq = tap_dq_i[IDX_W'(bidx)];
            end
        end
        pin_d.oe  = win;
        pin_d.dqs = beat_v & ~beat_hi;
        pin_d.dq  = beat_v ? beat_dq : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_q <= '0;
        end else begin
            pin_q <= pin_d;
        end
    end

    assign oe_o  = pin_q.oe;
    assign dqs_o = pin_q.dqs;
    assign dq_o  = pin_q.dq;

endmodule

// File: rtl/ddr_rd_serializer.sv
module ddr_rd_serializer
    import ddr_rd_ser_pkg::*;
#(
    parameter int unsigned DQ_W      = 8,
    parameter int unsigned LAT_MAX_H = 6
) (
    input  logic                 clk2x_i,
    input  logic                 rst_n_i,
    input  logic                 rd_start_i,
    input  logic [1:0]           bl_code_i,
    input  logic [1:0]           lat_code_i,
    input  logic [2*DQ_W-1:0]    word_i,
    output logic [DQ_W-1:0]      dq_o,
    output logic                 dqs_o,
    output logic                 oe_o
);

    localparam int unsigned TAP_N = LAT_MAX_H;

    logic                     slot_v;
    logic                     slot_hi;
    logic [DQ_W-1:0]          slot_dq;
    logic [LAT_W-1:0]         lat_h;
    logic [LEFT_W-1:0]        words_left;
    logic [TAP_N:1]           tap_v;
    logic [TAP_N:1]           tap_hi;
    logic [TAP_N:1][DQ_W-1:0] tap_dq;

    rd_word_feed #(.DQ_W(DQ_W)) feed_i (
        .clk          (clk2x_i),
        .rst_n        (rst_n_i),
        .rd_start_i   (rd_start_i),
        .bl_code_i    (bl_code_i),
        .lat_code_i   (lat_code_i),
        .word_i       (word_i),
        .slot_v_o     (slot_v),
        .slot_hi_o    (slot_hi),
        .slot_dq_o    (slot_dq),
        .lat_h_o      (lat_h),
        .words_left_o (words_left)
    );

    rd_slot_delay #(.DQ_W(DQ_W), .TAP_N(TAP_N)) delay_i (
        .clk      (clk2x_i),
        .rst_n    (rst_n_i),
        .in_v_i   (slot_v),
        .in_hi_i  (slot_hi),
        .in_dq_i  (slot_dq),
        .tap_v_o  (tap_v),
        .tap_hi_o (tap_hi),
        .tap_dq_o (tap_dq)
    );

    rd_beat_drive #(.DQ_W(DQ_W), .TAP_N(TAP_N)) drive_i (
        .clk      (clk2x_i),
        .rst_n    (rst_n_i),
        .lat_h_i  (lat_h),
        .tap_v_i  (tap_v),
        .tap_hi_i (tap_hi),
        .tap_dq_i (tap_dq),
        .oe_o     (oe_o),
        .dqs_o    (dqs_o),
        .dq_o     (dq_o)
    );

endmodule

// File: rtl/ddr_rd_serializer_chk.sv
module ddr_rd_serializer_chk #(
    parameter int unsigned DQ_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            oe,
    input logic            dqs,
    input logic [DQ_W-1:0] dq,
    input logic [2:0]      words_left
);

    // R9: released pins carry no level
    a_r9_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !oe |-> (dqs == 1'b0 && dq == '0));

    // R6: a high strobe beat is always followed by a driven low beat
    a_r6_strobe_toggles: assert property (@(posedge clk) disable iff (!rst_n)
        dqs |=> (oe && !dqs));

    // R7: the window opens low and stays low for a second cycle
    a_r7_preamble_open: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe) |-> !dqs);

    a_r7_preamble_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe) |=> (oe && !dqs));

    // R8: the window closes only after a low cycle
    a_r8_postamble: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(oe) |-> !$past(dqs));

    // R3: no burst holds more than four words
    a_r3_words_bound: assert property (@(posedge clk) disable iff (!rst_n)
        words_left <= 3'd3);

endmodule

bind ddr_rd_serializer ddr_rd_serializer_chk #(.DQ_W(DQ_W)) chk_i (
    .clk        (clk2x_i),
    .rst_n      (rst_n_i),
    .oe         (oe_o),
    .dqs        (dqs_o),
    .dq         (dq_o),
    .words_left (words_left)
);

// File: tb/ddr_rd_serializer_tb_top.sv
module ddr_rd_serializer_tb_top;

    localparam int DQ_W  = 8;
    localparam int N     = 320;
    localparam int END_E = 300;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              rd_start = 1'b0;
    logic [1:0]        bl_code = '0;
    logic [1:0]        lat_code = '0;
    logic [2*DQ_W-1:0] word = '0;
    logic [DQ_W-1:0]   dq;
    logic              dqs;
    logic              oe;

    always #5 clk = ~clk;

    ddr_rd_serializer #(.DQ_W(DQ_W)) dut_i (
        .clk2x_i    (clk),
        .rst_n_i    (rst_n),
        .rd_start_i (rd_start),
        .bl_code_i  (bl_code),
        .lat_code_i (lat_code),
        .word_i     (word),
        .dq_o       (dq),
        .dqs_o      (dqs),
        .oe_o       (oe)
    );

    // stimulus plan and expected pin timeline, indexed by fast edge
    logic              st_start [N];
    logic [1:0]        st_bl    [N];
    logic [1:0]        st_lat   [N];
    logic [2*DQ_W-1:0] st_word  [N];
    logic              ex_beat  [N];
    logic              ex_oe    [N];
    logic              ex_dqs   [N];
    logic [DQ_W-1:0]   ex_dq    [N];
    int                cat      [N];

    int  edge_n = -1;
    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    function automatic string cat_name(input int c);
        case (c)
            1:       return "R3 R4 R5 R6 R11 beat";
            2:       return "R7 preamble";
            3:       return "R8 postamble";
            4:       return "R10 seamless beat";
            5:       return "R2 odd-phase start ignored";
            default: return "R9 idle";
        endcase
    endfunction

    // behavioural model of one burst started on even edge e
    task automatic plan_burst(input int e, input int blc, input int latc, input int tag);
        int words;
        int lat;
        st_start[e] = 1'b1;
        st_bl[e]    = 2'(blc);
        st_lat[e]   = 2'(latc);
        words = (blc == 0) ? 1 : (blc == 1) ? 2 : 4;
        lat   = (latc == 0) ? 4 : (latc == 1) ? 5 : 6;
        for (int j = 0; j < words; j++) begin
            logic [DQ_W-1:0] lo;
            logic [DQ_W-1:0] hi;
            int b;
            lo = DQ_W'(e * 3 + j * 7 + 1);
            hi = ~lo ^ 8'h5A;
            st_word[e + 2*j] = {hi, lo};
            b = e + lat + 2*j;
            ex_beat[b] = 1'b1; ex_oe[b] = 1'b1; ex_dqs[b] = 1'b1; ex_dq[b] = lo; cat[b] = tag;
            ex_beat[b+1] = 1'b1; ex_oe[b+1] = 1'b1; ex_dqs[b+1] = 1'b0; ex_dq[b+1] = hi; cat[b+1] = tag;
        end
        for (int p = e + lat - 2; p < e + lat; p++) begin
            if (!ex_beat[p]) begin ex_oe[p] = 1'b1; cat[p] = 2; end
        end
        if (!ex_beat[e + lat + 2*words]) begin
            ex_oe[e + lat + 2*words] = 1'b1;
            cat[e + lat + 2*words] = 3;
        end
    endtask

    always @(posedge clk) begin
        if (rst_n) edge_n <= edge_n + 1;
    end

    // drive inputs for the next edge, away from the active edge
    always @(negedge clk) begin
        int nx;
        nx = edge_n + 1;
        if (nx >= 0 && nx < N) begin
            rd_start <= st_start[nx];
            bl_code  <= st_bl[nx];
            lat_code <= st_lat[nx];
            word     <= st_word[nx];
        end else begin
            rd_start <= 1'b0;
            word     <= '0;
        end
    end

    // compare against the model on every fast cycle
    always @(negedge clk) begin
        if (rst_n && !done && edge_n >= 0 && edge_n < N) begin
            checks++;
            if (oe !== ex_oe[edge_n] || dqs !== ex_dqs[edge_n] || dq !== ex_dq[edge_n]) begin
                errors++;
                $display("FAIL %s at edge %0d: got oe=%0b dqs=%0b dq=%h, expected oe=%0b dqs=%0b dq=%h",
                         cat_name(cat[edge_n]), edge_n, oe, dqs, dq,
                         ex_oe[edge_n], ex_dqs[edge_n], ex_dq[edge_n]);
            end
        end
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            st_start[i] = 1'b0;
            st_bl[i]    = 2'd3;
            st_lat[i]   = 2'd0;
            st_word[i]  = 16'hBEEF ^ 16'(i * 37);
            ex_beat[i]  = 1'b0;
            ex_oe[i]    = 1'b0;
            ex_dqs[i]   = 1'b0;
            ex_dq[i]    = '0;
            cat[i]      = 0;
        end
        plan_burst(10, 0, 0, 1);   // R3 two beats, R4 latency 4
        plan_burst(30, 1, 1, 1);   // R3 four beats, R4 half-cycle latency 5
        plan_burst(50, 2, 2, 1);   // R3 eight beats, R4 latency 6
        plan_burst(80, 1, 0, 1);   // R10 chain of three bursts
        plan_burst(84, 1, 0, 4);
        plan_burst(88, 0, 0, 4);
        // R2: start on an odd edge must leave the pins idle
        st_start[121] = 1'b1;
        st_bl[121]    = 2'd2;
        for (int i = 121; i < 140; i++) cat[i] = 5;
        plan_burst(150, 2, 1, 1);  // R10 seamless eight-beat pair at latency 5
        plan_burst(158, 2, 1, 4);
        plan_burst(190, 0, 2, 1);  // R10 one-core-cycle gap keeps window open
        plan_burst(194, 0, 2, 4);
        plan_burst(220, 3, 3, 1);  // R3 code 3 is 8 beats, R4 code 3 is 6

        repeat (3) @(negedge clk);
        // R1: reset state
        checks++;
        if (oe !== 1'b0 || dqs !== 1'b0 || dq !== '0) begin
            errors++;
            $display("FAIL R1 reset: got oe=%0b dqs=%0b dq=%h, expected 0 0 00", oe, dqs, dq);
        end
        rst_n = 1'b1;
        wait (edge_n >= END_E);
        @(negedge clk);
        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        done = 1'b1;
        checks++;
        errors++;
        $display("FAIL watchdog: run did not finish, got edge %0d, expected %0d", edge_n, END_E);
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule